// File: doc/BRIEF.md
# Global Motion Vector Selector

This block turns four per-frame local motion estimates into one global motion vector for a video stabilizer. Each frame, an upstream peak search delivers four candidates, one per fixed sub-image window. Each candidate is a signed horizontal and vertical displacement plus the amplitude of the correlation peak it came from. The block keeps the two candidates with the strongest peaks and averages them, per component, to form the frame's global vector.

The global vectors are summed into a saturating absolute position, one per axis. An external smoothing filter returns a smoothed position, and the block subtracts the raw position from it to give the correction vector. The correction path is combinational from the smoothed-position inputs and the current raw position.

Frames enter through a valid/ready handshake, and the pipeline takes one frame per clock. The global vector appears a fixed two cycles after a frame is accepted. A clear input zeroes the position at the start of a new shot.

Top module: `gmv_selector`

## Requirements
- R1: While `rst` is high at a clock edge, `in_ready` and `gmv_valid` go low and both positions go to zero. After the first edge with `rst` low, `in_ready` is high.
- R2: A frame is accepted at each rising edge where `in_valid` and `in_ready` are both high. For that frame, `gmv_valid` is high for exactly one cycle, starting at the second rising edge after the accepting edge. Frames may be accepted on consecutive cycles, and each produces its own pulse.
- R3: Lane i of `in_dx`, `in_dy` and `in_amp` sits at bits [i*W +: W], for i = 0..3. The two lanes with the largest unsigned amplitudes are selected. On equal amplitudes, the lane with the lower index ranks higher.
- R4: Each component of the global vector is the sum of the two selected signed components shifted right arithmetically by one. This rounds toward negative infinity, so for example -3 gives -2.
- R5: Each axis position adds its global vector component at the same edge that raises `gmv_valid`.
- R6: Each position is 16-bit signed and saturates at 32767 and -32768 instead of wrapping.
- R7: A high `clr` at a rising edge sets both positions to zero. This overrides an update at the same edge, and the global vector of that frame is still reported.
- R8: `cor_x` = `kal_x` - `pos_x` and `cor_y` = `kal_y` - `pos_y`, as 17-bit signed results, so the extreme differences do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous position clear |
| in_valid | input | 1 | Frame of four candidates is present |
| in_ready | output | 1 | Block accepts a frame |
| in_dx | input | 28 | Four signed 7-bit horizontal displacements |
| in_dy | input | 28 | Four signed 7-bit vertical displacements |
| in_amp | input | 64 | Four unsigned 16-bit peak amplitudes |
| kal_x | input | 16 | Smoothed horizontal position, signed |
| kal_y | input | 16 | Smoothed vertical position, signed |
| gmv_valid | output | 1 | Global vector valid, one-cycle pulse |
| gmv_x | output | 7 | Global horizontal vector, signed |
| gmv_y | output | 7 | Global vertical vector, signed |
| pos_x | output | 16 | Raw horizontal position, signed |
| pos_y | output | 16 | Raw vertical position, signed |
| cor_x | output | 17 | Horizontal correction, signed |
| cor_y | output | 17 | Vertical correction, signed |

## Verification
The bench drives frames with all amplitudes equal and with a three-way tie below a weaker first lane. A design that broke ties toward higher lanes, or that picked three lanes, would average the wrong pair. Negative odd sums and the most extreme component values expose truncation toward zero and loss of the sign bit. A long back-to-back stream drives both positions into opposite saturation limits and then steps back out. A wrapping accumulator, or a correction one bit too narrow, would show the wrong sign there. A clear raised on the very edge of an update catches a design that lets the update win.

// File: rtl/gmv_pkg.sv
package gmv_pkg;
    // number of sub-image windows supplying candidates each frame
    localparam int LANES   = 4;
    // bits needed to count how many lanes outrank a given lane
    localparam int RANK_W  = $clog2(LANES) + 1;
    // number of lanes that contribute to the global vector
    localparam int PICKS   = 2;
    // axes handled by the position path
    localparam int AXES    = 2;
endpackage

// File: rtl/gmv_rank_pick.sv
module gmv_rank_pick
    import gmv_pkg::*;
#(
    parameter int VW = 7,
    parameter int AW = 16
) (
    input  logic [LANES*VW-1:0] dx_flat,
    input  logic [LANES*VW-1:0] dy_flat,
    input  logic [LANES*AW-1:0] amp_flat,
    output logic [LANES-1:0]    pick,
    output logic signed [VW:0]  sum_x,
    output logic signed [VW:0]  sum_y
);
    logic [VW-1:0] dx_l  [LANES];
    logic [VW-1:0] dy_l  [LANES];
    logic [AW-1:0] amp_l [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dx_l[g]  = dx_flat[g*VW +: VW];
        assign dy_l[g]  = dy_flat[g*VW +: VW];
        assign amp_l[g] = amp_flat[g*AW +: AW];
    end

    // A lane is picked when fewer than PICKS lanes outrank it.
    // Lane j outranks lane i on a larger amplitude, or on an equal one with j < i.
    always_comb begin
        logic [RANK_W-1:0] beaten;
        for (int i = 0; i < LANES; i++) begin
            beaten = '0;
            for (int j = 0; j < LANES; j++) begin
                if (j != i) begin
                    if ((amp_l[j] > amp_l[i]) || ((amp_l[j] == amp_l[i]) && (j < i)))
                        beaten = beaten + 1'b1;
                end
            end
            pick[i] = (beaten < RANK_W'(PICKS));
        end
    end

    always_comb begin
        sum_x = '0;
        sum_y = '0;
        for (int i = 0; i < LANES; i++) begin
            if (pick[i]) begin
                sum_x = sum_x + {dx_l[i][VW-1], dx_l[i]};
                sum_y = sum_y + {dy_l[i][VW-1], dy_l[i]};
            end
        end
    end
endmodule

// File: rtl/gmv_pos_accum.sv
module gmv_pos_accum #(
    parameter int VW = 7,
    parameter int PW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 upd,
    input  logic signed [VW-1:0] inc,
    output logic signed [PW-1:0] pos
);
    localparam logic signed [PW:0] HI = {2'b00, {(PW-1){1'b1}}};
    localparam logic signed [PW:0] LO = {2'b11, {(PW-1){1'b0}}};

    typedef struct packed {
        logic signed [PW-1:0] pos;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        logic signed [PW:0] wide;
        acc_d = acc_q;
        wide  = {acc_q.pos[PW-1], acc_q.pos} + {{(PW+1-VW){inc[VW-1]}}, inc};
        if (upd) begin
            if (wide > HI)
                acc_d.pos = HI[PW-1:0];
            else if (wide < LO)
                acc_d.pos = LO[PW-1:0];
            else
                acc_d.pos = wide[PW-1:0];
        end
        if (clr)
            acc_d.pos = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end

    assign pos = acc_q.pos;

    // R6: at the top limit a non-negative step keeps the position there
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (upd && !clr && acc_q.pos == HI[PW-1:0] && !inc[VW-1]) |=> (acc_q.pos == HI[PW-1:0]));
    // R6: at the bottom limit a negative step keeps the position there
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        (upd && !clr && acc_q.pos == LO[PW-1:0] && inc[VW-1]) |=> (acc_q.pos == LO[PW-1:0]));
    // R7: a clear always leaves zero behind, whatever the update
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q.pos == '0));
endmodule

// File: rtl/gmv_selector.sv
module gmv_selector
    import gmv_pkg::*;
#(
    parameter int VW = 7,
    parameter int AW = 16,
    parameter int PW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [LANES*VW-1:0]  in_dx,
    input  logic [LANES*VW-1:0]  in_dy,
    input  logic [LANES*AW-1:0]  in_amp,
    input  logic signed [PW-1:0] kal_x,
    input  logic signed [PW-1:0] kal_y,
    output logic                 gmv_valid,
    output logic signed [VW-1:0] gmv_x,
    output logic signed [VW-1:0] gmv_y,
    output logic signed [PW-1:0] pos_x,
    output logic signed [PW-1:0] pos_y,
    output logic signed [PW:0]   cor_x,
    output logic signed [PW:0]   cor_y
);
    typedef struct packed {
        logic                 ready;
        logic                 s1_valid;
        logic signed [VW:0]   s1_sx;
        logic signed [VW:0]   s1_sy;
        logic                 gv_valid;
        logic signed [VW-1:0] gx;
        logic signed [VW-1:0] gy;
    } pipe_t;

    pipe_t pp_d, pp_q;

    logic [LANES-1:0]    pick;
    logic signed [VW:0]  sum_x, sum_y;
    logic                hs;

    gmv_rank_pick #(.VW(VW), .AW(AW)) u_pick (
        .dx_flat (in_dx),
        .dy_flat (in_dy),
        .amp_flat(in_amp),
        .pick    (pick),
        .sum_x   (sum_x),
        .sum_y   (sum_y)
    );

    assign hs = in_valid && pp_q.ready;

    always_comb begin
        logic signed [VW:0] hx, hy;
        pp_d          = pp_q;
        pp_d.ready    = 1'b1;
        pp_d.s1_valid = hs;
        if (hs) begin
            pp_d.s1_sx = sum_x;
            pp_d.s1_sy = sum_y;
        end
        hx = pp_q.s1_sx >>> 1;
        hy = pp_q.s1_sy >>> 1;
        pp_d.gv_valid = pp_q.s1_valid;
        if (pp_q.s1_valid) begin
            pp_d.gx = hx[VW-1:0];
            pp_d.gy = hy[VW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pp_q <= '0;
        else
            pp_q <= pp_d;
    end

    // per-axis position and correction path
    logic signed [VW-1:0] step [AXES];
    logic signed [PW-1:0] pos  [AXES];
    logic signed [PW-1:0] kal  [AXES];
    logic signed [PW:0]   cor  [AXES];

    assign step[0] = pp_d.gx;
    assign step[1] = pp_d.gy;
    assign kal[0]  = kal_x;
    assign kal[1]  = kal_y;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        gmv_pos_accum #(.VW(VW), .PW(PW)) u_acc (
            .clk(clk),
            .rst(rst),
            .clr(clr),
            .upd(pp_q.s1_valid),
            .inc(step[a]),
            .pos(pos[a])
        );
        assign cor[a] = {kal[a][PW-1], kal[a]} - {pos[a][PW-1], pos[a]};
    end

    assign in_ready  = pp_q.ready;
    assign gmv_valid = pp_q.gv_valid;
    assign gmv_x     = pp_q.gx;
    assign gmv_y     = pp_q.gy;
    assign pos_x     = pos[0];
    assign pos_y     = pos[1];
    assign cor_x     = cor[0];
    assign cor_y     = cor[1];

    // R3: every accepted frame selects exactly two lanes
    assert_two_picked_R3: assert property (@(posedge clk) disable iff (rst)
        hs |-> ($countones(pick) == PICKS));
    // R2: the vector arrives two edges after acceptance
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        hs |-> ##2 gmv_valid);
    // R1: nothing is reported the cycle right after reset is released
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> !gmv_valid);
endmodule

// File: tb/gmv_selector_bench.sv
module gmv_selector_bench;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 7;
    localparam int AW = 16;
    localparam int PW = 16;
    localparam int NL = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [NL*VW-1:0] in_dx = '0;
    logic [NL*VW-1:0] in_dy = '0;
    logic [NL*AW-1:0] in_amp = '0;
    logic signed [PW-1:0] kal_x = '0;
    logic signed [PW-1:0] kal_y = '0;
    logic gmv_valid;
    logic signed [VW-1:0] gmv_x, gmv_y;
    logic signed [PW-1:0] pos_x, pos_y;
    logic signed [PW:0] cor_x, cor_y;

    int checks = 0;
    int fails = 0;
    int pulses = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (gmv_valid === 1'b1) pulses++;

    gmv_selector u_gmv_selector (
        .clk(clk), .rst(rst), .clr(clr),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_dx(in_dx), .in_dy(in_dy), .in_amp(in_amp),
        .kal_x(kal_x), .kal_y(kal_y),
        .gmv_valid(gmv_valid), .gmv_x(gmv_x), .gmv_y(gmv_y),
        .pos_x(pos_x), .pos_y(pos_y), .cor_x(cor_x), .cor_y(cor_y)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load(input int dx[4], input int dy[4], input int am[4]);
        for (int i = 0; i < NL; i++) begin
            in_dx[i*VW +: VW]  = VW'(dx[i]);
            in_dy[i*VW +: VW]  = VW'(dy[i]);
            in_amp[i*AW +: AW] = AW'(am[i]);
        end
    endtask

    // one frame; checks pulse timing (R2), vector (R3/R4) and position (R5/R7)
    task automatic run_frame(input int dx[4], input int dy[4], input int am[4],
                             input int ex, input int ey, input int epx, input int epy,
                             input bit clr_e2, input string tag);
        @(negedge clk);
        load(dx, dy, am);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R2 no pulse after one edge"}, int'(gmv_valid), 0);
        if (clr_e2) clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0;
        chk({tag, " R2 pulse after two edges"}, int'(gmv_valid), 1);
        chk({tag, " R3 R4 gmv_x"}, int'(gmv_x), ex);
        chk({tag, " R3 R4 gmv_y"}, int'(gmv_y), ey);
        chk({tag, " R5 pos_x"}, int'(pos_x), epx);
        chk({tag, " R5 pos_y"}, int'(pos_y), epy);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R2 single-cycle pulse"}, int'(gmv_valid), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 in_ready low in reset", int'(in_ready), 0);
        chk("R1 gmv_valid low in reset", int'(gmv_valid), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 in_ready high after reset", int'(in_ready), 1);
        chk("R1 pos_x zero", int'(pos_x), 0);
        chk("R1 pos_y zero", int'(pos_y), 0);
    endtask

    task automatic t_basic();
        run_frame('{3, 10, -4, 20}, '{1, -6, 7, 0}, '{100, 500, 300, 50},
                  3, 0, 3, 0, 1'b0, "basic");
    endtask

    task automatic t_ties();
        // all equal: lanes 0 and 1; dy sum -3 floors to -2
        run_frame('{5, -9, 30, 30}, '{-1, -2, 31, 31}, '{200, 200, 200, 200},
                  -2, -2, 1, -2, 1'b0, "tie-all");
        // three-way tie at top: lanes 1 and 2, extreme components
        run_frame('{0, -64, -63, 40}, '{0, 63, 62, 40}, '{7, 9, 9, 9},
                  -64, 62, -63, 60, 1'b0, "tie-three");
    endtask

    task automatic t_corr();
        @(negedge clk);
        kal_x = 16'sd100;
        kal_y = -16'sd50;
        #1;
        chk("R8 cor_x", int'(cor_x), 163);
        chk("R8 cor_y", int'(cor_y), -110);
        kal_x = '0;
        kal_y = '0;
    endtask

    task automatic t_clear();
        run_frame('{0, 0, 4, 6}, '{0, 0, -3, -4}, '{1, 2, 3, 4},
                  5, -4, 0, 0, 1'b1, "clr-with-update R7");
        run_frame('{0, 0, 4, 6}, '{0, 0, -3, -4}, '{1, 2, 3, 4},
                  5, -4, 5, -4, 1'b0, "after-clr");
        @(negedge clk);
        clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0;
        chk("R7 pos_x cleared", int'(pos_x), 0);
        chk("R7 pos_y cleared", int'(pos_y), 0);
    endtask

    task automatic t_saturate();
        @(negedge clk);
        pulses = 0;
        load('{63, 63, 63, 63}, '{-64, -64, -64, -64}, '{1, 1, 1, 1});
        in_valid = 1'b1;
        repeat (600) @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 one pulse per streamed frame", pulses, 600);
        chk("R6 pos_x held at top", int'(pos_x), 32767);
        chk("R6 pos_y held at bottom", int'(pos_y), -32768);
        #1;
        chk("R8 cor_x at limit", int'(cor_x), -32767);
        chk("R8 cor_y at limit", int'(cor_y), 32768);
        run_frame('{-1, -1, -1, -1}, '{1, 1, 1, 1}, '{5, 5, 5, 5},
                  -1, 1, 32766, -32767, 1'b0, "leave-limit R6");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_ties();
        t_corr();
        t_clear();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule